// File: doc/BRIEF.md
# Ultra DMA Device-Side Data-In Burst Sender

This block is the device end of a parallel DMA data-in burst. It takes 16-bit words from a word FIFO, presents each on the data bus and toggles a data strobe to mark it. Rising and falling strobe transitions each carry one word. The block watches a host ready level. When the host pauses, strobing stops within a bounded number of cycles and picks up again with the next edge once the host is ready.

A word marked as last in the FIFO ends the burst. No further strobe edges follow it. The DMA request stays up for a minimum settle gap, then drops, and the bus output enable is released within a bounded gap after that. The burst counts as terminated once the host has raised its stop level and the bus is released. The block then returns to idle and may request a new burst.

The controller has five states. ST_IDLE goes to ST_REQUEST when the FIFO has a word. ST_REQUEST goes to ST_STREAM when the host is ready and stop is low; the bus enable switches on at that transition. ST_STREAM goes to ST_SETTLE on the strobe edge of the last word. ST_SETTLE goes to ST_RELEASE when the settle timer expires, which drops the request. ST_RELEASE goes to ST_IDLE when stop is high and the bus is released. All gap limits are parameters counted in clock cycles.

Top module: `udma_burst_tx`

## Requirements
- R1: During and right after reset, dma_req, bus_oe, data_strobe and fifo_pop are all 0.
- R2: A word in the FIFO while idle raises dma_req within two cycles. bus_oe and strobe edges stay off until host_rdy is 1 and host_stop is 0.
- R3: Every transition of data_strobe, rising or falling, delivers the next FIFO word in order. bus_data holds that word in the cycle before the transition and is unchanged across it.
- R4: After host_rdy goes to 0, no strobe transition occurs once T_RFS cycles have passed. Transitions resume after host_rdy returns to 1.
- R5: fifo_pop is 1 only while fifo_valid is 1. If the FIFO runs empty mid-burst, data_strobe holds its level and dma_req stays 1 until words arrive.
- R6: A word popped with fifo_last = 1 is the final word of the burst, and no strobe transition follows its own. dma_req falls exactly T_SS cycles after that final transition.
- R7: Once dma_req has fallen, it stays 0 until host_stop has been seen at 1 with the bus released, even if the FIFO already holds words.
- R8: bus_oe falls no later than T_AZ cycles after dma_req falls.
- R9: With host_stop at 1 and the bus released, the block returns to idle. A waiting word then raises dma_req again; with nothing waiting, dma_req and bus_oe stay 0.
- R10: data_strobe transitions only while dma_req and bus_oe are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_valid | input | 1 | FIFO holds a word |
| fifo_data | input | DATA_W | Word at the FIFO head |
| fifo_last | input | 1 | Head word is the final word of the burst |
| fifo_pop | output | 1 | Consume the head word at this clock edge |
| host_rdy | input | 1 | Host ready level, 1 = accept words |
| host_stop | input | 1 | Host stop level, 1 = stop asserted |
| dma_req | output | 1 | DMA request toward the host |
| data_strobe | output | 1 | Data strobe; each transition marks one word |
| bus_data | output | DATA_W | Value driven on the data bus |
| bus_oe | output | 1 | Data bus output enable |

## Verification
The main function is driven with several word patterns. Alternating halves show that both strobe directions carry words. A walking single bit catches swapped or stale words. A single-word burst exercises the final-word path with no body. An ascending count covers longer bursts that are interrupted by a host pause and by a FIFO underrun. A start with host ready held low separates requesting from driving the bus. A word queued during termination shows that the request stays down until the host stop handshake completes, and that it then starts a fresh burst.

// File: rtl/udma_tx_pkg.sv
package udma_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_STREAM,
        ST_SETTLE,
        ST_RELEASE
    } tx_state_t;

endpackage

// File: rtl/udma_tx_gap_timer.sv
module udma_tx_gap_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= W'(LIMIT);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // high in the last cycle of the window; the owner moves on at the next edge
    assign expire = (cnt == W'(1));

endmodule

// File: rtl/udma_tx_word_stage.sv
module udma_tx_word_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              fire,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic [DATA_W-1:0] word_q,
    output logic              loaded,
    output logic              last_pend,
    output logic              strobe_q
);
    // a word is placed on the bus one edge before the strobe toggle that marks it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q    <= '0;
            loaded    <= 1'b0;
            last_pend <= 1'b0;
            strobe_q  <= 1'b0;
        end else if (take) begin
            word_q    <= in_data;
            loaded    <= 1'b1;
            last_pend <= in_last;
        end else if (fire) begin
            strobe_q  <= ~strobe_q;
            loaded    <= 1'b0;
        end
    end

endmodule

// File: rtl/udma_burst_tx.sv
module udma_burst_tx
    import udma_tx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int T_RFS  = 3,
    parameter int T_SS   = 4,
    parameter int T_AZ   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_valid,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_last,
    output logic              fifo_pop,
    input  logic              host_rdy,
    input  logic              host_stop,
    output logic              dma_req,
    output logic              data_strobe,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe
);
    localparam bit EARLY_RELEASE = (T_AZ == 0);

    tx_state_t state, state_n;
    logic      rdy_ok;
    logic      loaded, last_pend;
    logic      take, fire;
    logic      settle_done;
    logic      oe_q;

    // host ready path: a register stage when the pause window allows it
    generate
        if (T_RFS >= 2) begin : g_rdy_reg
            logic rdy_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) rdy_q <= 1'b0;
                else        rdy_q <= host_rdy;
            end
            assign rdy_ok = rdy_q;
        end else begin : g_rdy_direct
            assign rdy_ok = host_rdy;
        end
    endgenerate

    assign take = (state == ST_STREAM) && !loaded && fifo_valid;
    assign fire = (state == ST_STREAM) && loaded && rdy_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (fifo_valid)             state_n = ST_REQUEST;
            ST_REQUEST: if (rdy_ok && !host_stop)   state_n = ST_STREAM;
            ST_STREAM:  if (fire && last_pend)      state_n = ST_SETTLE;
            ST_SETTLE:  if (settle_done)            state_n = ST_RELEASE;
            ST_RELEASE: if (host_stop && !oe_q)     state_n = ST_IDLE;
            default:                                state_n = ST_IDLE;
        endcase
    end

    // output process: bus enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (state == ST_REQUEST && state_n == ST_STREAM) begin
            oe_q <= 1'b1;
        end else if (EARLY_RELEASE ? (state_n == ST_RELEASE) : (state == ST_RELEASE)) begin
            oe_q <= 1'b0;
        end
    end

    udma_tx_word_stage #(.DATA_W(DATA_W)) i_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .fire      (fire),
        .in_data   (fifo_data),
        .in_last   (fifo_last),
        .word_q    (bus_data),
        .loaded    (loaded),
        .last_pend (last_pend),
        .strobe_q  (data_strobe)
    );

    udma_tx_gap_timer #(.LIMIT(T_SS)) i_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (fire && last_pend),
        .expire (settle_done)
    );

    assign fifo_pop = take;
    assign dma_req  = (state == ST_REQUEST) || (state == ST_STREAM) || (state == ST_SETTLE);
    assign bus_oe   = oe_q;

endmodule

// File: rtl/udma_burst_tx_chk.sv
module udma_burst_tx_chk #(
    parameter int DATA_W = 16,
    parameter int T_RFS  = 3,
    parameter int T_SS   = 4,
    parameter int T_AZ   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_valid,
    input logic              fifo_pop,
    input logic              host_rdy,
    input logic              host_stop,
    input logic              dma_req,
    input logic              data_strobe,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_oe
);
    localparam int CW = 8;

    logic          strb_d, req_d, term_q;
    logic [CW-1:0] since_edge, since_unrdy, since_drop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_d      <= 1'b0;
            req_d       <= 1'b0;
            term_q      <= 1'b0;
            since_edge  <= '0;
            since_unrdy <= '0;
            since_drop  <= '0;
        end else begin
            strb_d <= data_strobe;
            req_d  <= dma_req;
            term_q <= (term_q || (req_d && !dma_req)) && !(host_stop && !bus_oe);
            if (data_strobe != strb_d)  since_edge <= CW'(1);
            else if (since_edge != '1)  since_edge <= since_edge + 1'b1;
            if (host_rdy)               since_unrdy <= '0;
            else if (since_unrdy != '1) since_unrdy <= since_unrdy + 1'b1;
            if (dma_req)                since_drop <= '0;
            else if (since_drop != '1)  since_drop <= since_drop + 1'b1;
        end
    end

    p_bus_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_strobe != $past(data_strobe)) |-> (bus_data == $past(bus_data)));

    p_pause_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rdy && since_unrdy >= CW'(T_RFS)) |-> $stable(data_strobe));

    p_pop_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> fifo_valid);

    p_settle_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_req) |-> (since_edge >= CW'(T_SS)));

    p_no_rereq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> !term_q);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && since_drop >= CW'(T_AZ)) |-> !bus_oe);

    p_edge_in_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_strobe != $past(data_strobe)) |-> (dma_req && bus_oe));

endmodule

bind udma_burst_tx udma_burst_tx_chk #(
    .DATA_W (DATA_W),
    .T_RFS  (T_RFS),
    .T_SS   (T_SS),
    .T_AZ   (T_AZ)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_valid  (fifo_valid),
    .fifo_pop    (fifo_pop),
    .host_rdy    (host_rdy),
    .host_stop   (host_stop),
    .dma_req     (dma_req),
    .data_strobe (data_strobe),
    .bus_data    (bus_data),
    .bus_oe      (bus_oe)
);

// File: tb/test_udma_burst_tx.sv
module test_udma_burst_tx;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 16;
    localparam int T_RFS = 3;
    localparam int T_SS  = 4;
    localparam int T_AZ  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_valid = 1'b0;
    logic [DW-1:0] fifo_data = '0;
    logic          fifo_last = 1'b0;
    logic          fifo_pop;
    logic          host_rdy = 1'b0;
    logic          host_stop = 1'b1;
    logic          dma_req, data_strobe, bus_oe;
    logic [DW-1:0] bus_data;

    int n_checks = 0;
    int n_errors = 0;
    int edge_cnt = 0;

    logic [DW:0]   src_q[$];
    logic [DW-1:0] exp_q[$];

    udma_burst_tx #(.DATA_W(DW), .T_RFS(T_RFS), .T_SS(T_SS), .T_AZ(T_AZ)) i_udma_burst_tx (
        .clk(clk), .rst_n(rst_n), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
        .fifo_last(fifo_last), .fifo_pop(fifo_pop), .host_rdy(host_rdy),
        .host_stop(host_stop), .dma_req(dma_req), .data_strobe(data_strobe),
        .bus_data(bus_data), .bus_oe(bus_oe)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    // driver: one item goes to the FIFO model and to the scoreboard
    task automatic push_word(input logic [DW-1:0] w, input bit last);
        src_q.push_back({last, w});
        exp_q.push_back(w);
    endtask

    // FIFO model: a pop seen in one cycle removes the head in the next
    initial begin
        bit pop_seen = 1'b0;
        forever begin
            @(negedge clk);
            if (pop_seen && src_q.size() > 0) void'(src_q.pop_front());
            pop_seen   = 1'b0;
            fifo_valid = (src_q.size() > 0);
            fifo_data  = (src_q.size() > 0) ? src_q[0][DW-1:0] : '0;
            fifo_last  = (src_q.size() > 0) ? src_q[0][DW] : 1'b0;
            #1;
            pop_seen = fifo_pop && fifo_valid;
        end
    end

    // monitor: scoreboard compare on every strobe transition, gap timing
    initial begin
        logic prev_strb = 1'b0, prev_req = 1'b0, prev_oe = 1'b0;
        int   since_edge = 0, since_drop = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (data_strobe != prev_strb) begin
                    edge_cnt++;
                    since_edge = 0;
                    chk(dma_req && bus_oe, "R10", "strobe edge outside burst",
                        {30'd0, dma_req, bus_oe}, 32'h3);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3", "strobe edge with no word expected", bus_data, 0);
                    end else begin
                        logic [DW-1:0] w;
                        w = exp_q.pop_front();
                        chk(bus_data == w, "R3", "word at strobe edge", bus_data, w);
                    end
                end else begin
                    since_edge++;
                end
                if (prev_req && !dma_req) begin
                    chk(since_edge == T_SS, "R6", "request drop after last edge",
                        since_edge, T_SS);
                    since_drop = 0;
                end else if (!dma_req) begin
                    since_drop++;
                end
                if (prev_oe && !bus_oe)
                    chk(!dma_req && since_drop <= T_AZ, "R8", "bus release gap",
                        since_drop, T_AZ);
            end
            prev_strb = data_strobe;
            prev_req  = dma_req;
            prev_oe   = bus_oe;
        end
    end

    task automatic wait_edges(input int target);
        for (int t = 0; t < 2000 && edge_cnt < target; t++) step(1);
    endtask

    task automatic wait_done();
        for (int t = 0; t < 3000 && (exp_q.size() != 0 || dma_req || src_q.size() != 0); t++)
            step(1);
        chk(exp_q.size() == 0 && !dma_req, "R6", "all words sent then request dropped",
            exp_q.size(), 0);
    endtask

    task automatic finish_burst(input bit tempt);
        bit hi = 1'b0;
        wait_done();
        if (tempt) push_word(16'hC35A, 1'b1);
        for (int i = 0; i < 6; i++) begin
            step(1);
            if (dma_req) hi = 1'b1;
        end
        chk(!hi, "R7", "request stayed low before stop", hi, 0);
        chk(!bus_oe, "R8", "bus released before stop", bus_oe, 0);
        host_stop = 1'b1;
        step(4);
        if (tempt) begin
            chk(dma_req && !bus_oe, "R9", "new request after stop, bus still off",
                {30'd0, dma_req, bus_oe}, 32'h2);
            host_stop = 1'b0;
            wait_done();
            host_stop = 1'b1;
            step(4);
        end
        chk(!dma_req && !bus_oe, "R9", "idle after stop", {30'd0, dma_req, bus_oe}, 0);
        host_stop = 1'b0;
        step(1);
    endtask

    initial begin
        int base;
        int e;
        step(3);
        chk(!dma_req && !bus_oe && !data_strobe && !fifo_pop, "R1", "outputs in reset",
            {28'd0, dma_req, bus_oe, data_strobe, fifo_pop}, 0);
        rst_n = 1'b1;
        step(3);
        chk(!dma_req && !bus_oe && !data_strobe && !fifo_pop, "R1", "outputs after reset",
            {28'd0, dma_req, bus_oe, data_strobe, fifo_pop}, 0);
        host_stop = 1'b0;

        // R2: request while host not ready
        base = edge_cnt;
        for (int i = 0; i < 3; i++) push_word(DW'(16'h1000 + i), i == 2);
        step(3);
        chk(dma_req, "R2", "request raised", dma_req, 1);
        step(6);
        chk(!bus_oe && edge_cnt == base, "R2", "no drive before host ready",
            {31'd0, bus_oe}, 0);
        host_rdy = 1'b1;
        finish_burst(1'b1);

        // alternating halves
        for (int i = 0; i < 8; i++) push_word((i % 2) ? 16'h5555 : 16'hAAAA, i == 7);
        finish_burst(1'b0);

        // walking single bit
        for (int i = 0; i < 16; i++) push_word(DW'(1) << i, i == 15);
        finish_burst(1'b0);

        // R4: host pause mid-burst
        base = edge_cnt;
        for (int i = 0; i < 12; i++) push_word(DW'(16'h3C00 + i), i == 11);
        wait_edges(base + 3);
        host_rdy = 1'b0;
        step(T_RFS);
        e = edge_cnt;
        step(10);
        chk(edge_cnt == e, "R4", "no strobe edge during pause", edge_cnt, e);
        chk(dma_req, "R4", "request held during pause", dma_req, 1);
        host_rdy = 1'b1;
        step(4);
        chk(edge_cnt > e, "R4", "strobe resumed after pause", edge_cnt, e + 1);
        finish_burst(1'b0);

        // R5: FIFO underrun mid-burst
        base = edge_cnt;
        for (int i = 0; i < 3; i++) push_word(DW'(16'h7E00 + i), 1'b0);
        wait_edges(base + 3);
        step(2);
        e = edge_cnt;
        step(10);
        chk(edge_cnt == e && dma_req, "R5", "strobe held while FIFO empty", edge_cnt, e);
        chk(!fifo_pop, "R5", "no pop while FIFO empty", fifo_pop, 0);
        for (int i = 0; i < 3; i++) push_word(DW'(16'h7E10 + i), i == 2);
        finish_burst(1'b0);

        chk(exp_q.size() == 0, "R3", "every word delivered", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule